// File: doc/BRIEF.md
# Dithered Pulse-Width Modulator

This block drives four PWM pins from one shared timebase. A power-of-two prescaler divides the system clock to make a tick. A five-bit tick counter makes every PWM cycle exactly 32 ticks long, and a three-bit frame counter groups eight cycles into a frame. Each channel holds an 8-bit setting. The upper five bits give a coarse high time. The lower three bits act as a binary rate multiplier: they stretch chosen cycles of the frame by one tick, so the mean duty has 8-bit resolution while the period stays fixed.

Software writes a channel's setting through a one-cycle write strobe. The value waits in a pending register and becomes active only when a new frame begins, so a cycle never comes out partly old and partly new. A per-channel enable forces a pin low without stopping the shared counters.

Top module: `dpwm_top`

## Requirements
- R1: The tick occurs once every 2^(pre_sel+1) clocks: select 0 gives 2 clocks per tick, 1 gives 4, 2 gives 8 and 3 gives 16.
- R2: Each PWM cycle is 32 ticks long, and eight consecutive cycles form a frame. Frame positions are numbered 0 to 7.
- R3: The duty field D is bits [7:3] of the written byte. In a cycle that is not stretched, the pin is high for the first D ticks and low for the remaining 32−D ticks.
- R4: The dither field B is bits [2:0] of the written byte. A stretched cycle is high for D+1 ticks. If B bit 2 is set, the cycles at odd frame positions are stretched. If B bit 1 is set, positions 2 and 6 are stretched. If B bit 0 is set, position 4 is stretched. A frame therefore has exactly B stretched cycles.
- R5: After reset every setting is zero and every pin is low.
- R6: A written value takes effect only at the start of the next frame. A write made in the middle of a frame leaves that frame unchanged.
- R7: While a channel's enable is low, its pin is low. The shared counters keep running, so the channel rejoins the common phase when it is enabled again.
- R8: With D=31, a stretched cycle is high for all 32 ticks.
- R9: wr_chan selects which channel a write reaches. All channels share one tick and one cycle and frame phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_sel | input | 2 | Prescaler select; the tick period is 2^(pre_sel+1) clocks |
| wr_en | input | 1 | Write strobe for one clock |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Setting: duty in [7:3], dither in [2:0] |
| out_en | input | 4 | Per-channel output enable |
| pwm_out | output | 4 | PWM pins |

## Verification
The assertions assume that the prescaler never divides by less than two, so two ticks never fall on adjacent clocks. They also assume that the write channel number is always in range. The stimulus holds pre_sel still for whole measured frames. It changes the enables and write signals only just after a falling edge, and it addresses only the four channels that exist. The reference model follows every select change anyway, so its per-clock comparison holds across changes as well.

// File: rtl/dpwm_pkg.sv
// Shared widths and the dither placement rule for the dithered PWM.
package dpwm_pkg;
    localparam int TICK_W = 5;   // 32 ticks per PWM cycle
    localparam int FRM_W  = 3;   // 8 cycles per frame
    localparam int DUTY_W = 5;   // coarse duty field
    localparam int DITH_W = 3;   // rate-multiplier field
    localparam int DATA_W = DUTY_W + DITH_W;

    // Returns 1 when the cycle at frame position f is stretched by dither b.
    function automatic logic dither_hit(input logic [DITH_W-1:0] b,
                                        input logic [FRM_W-1:0]  f);
        logic hit;
        hit = (b[2] && f[0])
           || (b[1] && (f[1:0] == 2'b10))
           || (b[0] && (f == 3'd4));
        return hit;
    endfunction
endpackage

// File: rtl/dpwm_prescaler.sv
// Prescaler: a free-running divider that pulses tick for one clock every
// 2^(sel+1) clocks. Assumes that sel changes only rarely; a change takes effect at once.
module dpwm_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 1 << SEL_W;

    logic [CNT_W-1:0] div_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] mask;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tick when all bits below the selected division are ones.
    always_comb begin
        span = (CNT_W+1)'(2) << sel;
        mask = CNT_W'(span - 1'b1);
        tick = &(div_q | ~mask);
    end
endmodule

// File: rtl/dpwm_timebase.sv
// Timebase: the tick position within a 32-tick cycle and the cycle position
// within an 8-cycle frame. frame_wrap flags the tick that starts a new frame.
module dpwm_timebase
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [TICK_W-1:0] pos,
    output logic [FRM_W-1:0]  frame,
    output logic              frame_wrap
);
    logic cycle_end;

    // End of the last tick of a cycle.
    always_comb begin
        cycle_end  = tick && (&pos);
        frame_wrap = cycle_end && (&frame);
    end

    // Tick position; wraps naturally at 32.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (tick) pos <= pos + 1'b1;
    end

    // Frame position; steps once per completed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         frame <= '0;
        else if (cycle_end) frame <= frame + 1'b1;
    end
endmodule

// File: rtl/dpwm_channel.sv
// One PWM channel: a pending setting written at any time, an active setting
// loaded at frame start, and the comparison that forms the pin.
// Assumes that pos and frame come from the shared timebase.
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic [TICK_W-1:0] pos,
    input  logic [FRM_W-1:0]  frame,
    input  logic              en,
    output logic              pwm
);
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] act_q;
    logic              stretch;
    logic [DUTY_W:0]   high_len;

    // Pending setting takes every write addressed to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (wr_hit) pend_q <= wr_data;
    end

    // Active setting changes only on the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= pend_q;
    end

    // High length of this cycle and the pin compare.
    always_comb begin
        stretch  = dither_hit(act_q[DITH_W-1:0], frame);
        high_len = {1'b0, act_q[DATA_W-1:DITH_W]} + {{DUTY_W{1'b0}}, stretch};
        pwm      = en && ({1'b0, pos} < high_len);
    end
endmodule

// File: rtl/dpwm_top.sv
// Dithered PWM top: one prescaler and one timebase shared by NCH channels,
// with a single write port. Assumes that wr_chan addresses an existing channel.
module dpwm_top
    import dpwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SEL_W = 2,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  pre_sel,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NCH-1:0]    out_en,
    output logic [NCH-1:0]    pwm_out
);
    logic              tick;
    logic [TICK_W-1:0] pos;
    logic [FRM_W-1:0]  frame;
    logic              frame_wrap;

    dpwm_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (pre_sel),
        .tick  (tick)
    );

    dpwm_timebase u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pos        (pos),
        .frame      (frame),
        .frame_wrap (frame_wrap)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        dpwm_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && (wr_chan == CH_W'(gi))),
            .wr_data (wr_data),
            .load    (frame_wrap),
            .pos     (pos),
            .frame   (frame),
            .en      (out_en[gi]),
            .pwm     (pwm_out[gi])
        );
    end
endmodule

// File: rtl/dpwm_checker.sv
// Properties of the dithered PWM timebase and pins, bound into dpwm_top.
module dpwm_checker
    import dpwm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [TICK_W-1:0] pos,
    input logic [FRM_W-1:0]  frame,
    input logic [NCH-1:0]    out_en,
    input logic [NCH-1:0]    pwm_out
);
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos)); // R1

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos == '1) |=> (pos == '0)); // R2

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos == '1) |=> (frame == FRM_W'($past(frame) + 1'b1))); // R2

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && pos == '1) |=> $stable(frame)); // R2

    for (genvar gi = 0; gi < NCH; gi++) begin : g_pin
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[gi] |-> !pwm_out[gi]); // R7
    end
endmodule

bind dpwm_top dpwm_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pos     (pos),
    .frame   (frame),
    .out_en  (out_en),
    .pwm_out (pwm_out)
);

// File: tb/dpwm_top_bench.sv
`timescale 1ns/1ps
module dpwm_top_bench;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] out_en = 4'hF;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;

    dpwm_top u_dpwm_top (
        .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_data(wr_data), .out_en(out_en), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    // ---------------- behavioural reference model ----------------
    int m_cnt = 0, m_pos = 0, m_frame = 0;
    int m_pend [NCH];
    int m_act  [NCH];
    bit m_fload = 0;

    function automatic int extra(int b, int f);
        int n = 0;
        if ((b & 4) != 0 && (f % 2) == 1) n++;
        if ((b & 2) != 0 && (f % 4) == 2) n++;
        if ((b & 1) != 0 && f == 4)       n++;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pos = 0; m_frame = 0; m_fload = 0;
            for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_act[i] = 0; end
        end else begin
            int per;
            per = 2 << pre_sel;
            m_fload = 0;
            if ((m_cnt % per) == per - 1) begin
                if (m_pos == 31) begin
                    m_pos = 0;
                    if (m_frame == 7) begin
                        m_frame = 0;
                        m_fload = 1;
                        for (int i = 0; i < NCH; i++) m_act[i] = m_pend[i];
                    end else m_frame++;
                end else m_pos++;
            end
            if (wr_en) m_pend[wr_chan] = wr_data;
            m_cnt = (m_cnt + 1) % 16;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R2 R3 R4 R7 R9).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                int hi;
                hi = (out_en[i] && m_pos < (m_act[i] / 8) + extra(m_act[i] % 8, m_frame)) ? 1 : 0;
                if (pwm_out[i] !== hi[0])
                    check("R2", int'(pwm_out[i]), hi, $sformatf("per-clock pin %0d", i));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int meas [NCH][8];

    task automatic write_reg(int ch, int val);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_chan = 2'(ch); wr_data = 8'(val);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Measures one frame of high clocks per channel per cycle. When mid_val >= 0,
    // that value is written to channel 0 in the middle of the frame.
    task automatic measure(bit skip, int mid_val);
        int per;
        if (skip) @(negedge clk);
        while (!m_fload) @(negedge clk);
        per = 2 << pre_sel;
        for (int i = 0; i < NCH; i++) for (int f = 0; f < 8; f++) meas[i][f] = 0;
        for (int k = 0; k < per * 256; k++) begin
            for (int i = 0; i < NCH; i++) if (pwm_out[i]) meas[i][k / (per * 32)]++;
            if (mid_val >= 0 && k == 100) begin
                #1; wr_en = 1'b1; wr_chan = 2'd0; wr_data = 8'(mid_val);
            end
            if (mid_val >= 0 && k == 101) begin #1; wr_en = 1'b0; end
            @(negedge clk);
        end
    endtask

    // Compares every measured cycle of one channel with its written value.
    task automatic expect_ch(int ch, int val, bit en, string req);
        int per = 2 << pre_sel;
        for (int f = 0; f < 8; f++) begin
            int exp = en ? per * ((val / 8) + extra(val % 8, f)) : 0;
            check(req, meas[ch][f], exp, $sformatf("ch%0d val %0h cycle %0d", ch, val, f));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check("R2", 0, 1, "watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R5", int'(pwm_out), 0, "pins low in reset");
        #1 rst_n = 1'b1;

        // R5: reset values give all-low pins over a whole frame.
        measure(1, -1);
        for (int i = 0; i < NCH; i++) expect_ch(i, 0, 1, "R5");

        // R3 R4 R8 R9: distinct values per channel, divide by 2.
        write_reg(0, 'h83); write_reg(1, 'h0D); write_reg(2, 'hFF); write_reg(3, 'hF8);
        measure(1, -1);
        expect_ch(0, 'h83, 1, "R4");
        expect_ch(1, 'h0D, 1, "R4");
        expect_ch(2, 'hFF, 1, "R8");
        expect_ch(3, 'hF8, 1, "R3");
        check("R4", meas[0][0]+meas[0][1]+meas[0][2]+meas[0][3]+meas[0][4]+meas[0][5]
              +meas[0][6]+meas[0][7], 2 * (16 * 8 + 3), "frame total for 0x83");

        // R1: other prescaler settings scale the same waveform.
        #1 pre_sel = 2'd1;
        measure(1, -1);
        expect_ch(0, 'h83, 1, "R1");
        #1 pre_sel = 2'd3;
        measure(1, -1);
        expect_ch(0, 'h83, 1, "R1");
        expect_ch(1, 'h0D, 1, "R1");
        #1 pre_sel = 2'd2;
        write_reg(2, 'h52); write_reg(3, 'h07);
        measure(1, -1);
        expect_ch(2, 'h52, 1, "R1");
        expect_ch(3, 'h07, 1, "R3");

        // R6: a write in the middle of a frame waits for the next frame.
        #1 pre_sel = 2'd0;
        write_reg(0, 'h11);
        measure(1, 'hA6);
        expect_ch(0, 'h11, 1, "R6");
        measure(0, -1);
        expect_ch(0, 'hA6, 1, "R6");

        // R7: disabled channels stay low and the rest are undisturbed (R9).
        #1 out_en = 4'b0101;
        measure(1, -1);
        expect_ch(0, 'hA6, 1, "R7");
        expect_ch(1, 'h0D, 0, "R7");
        expect_ch(2, 'h52, 1, "R9");
        expect_ch(3, 'h07, 0, "R7");
        #1 out_en = 4'hF;
        measure(1, -1);
        expect_ch(1, 'h0D, 1, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule